// File: doc/BRIEF.md
# Cache Control Register with Interrupt Freeze

A single memory-mapped control word for the instruction and data caches of a small processor core. Each cache has a 2-bit operating state (disabled, frozen, enabled) that software sets through a plain write port. Software can also arm a per-cache freeze-on-interrupt enable. When the core acknowledges an interrupt, every cache that is enabled and armed drops to the frozen state on its own. This keeps interrupt handlers from displacing the cached working set of the interrupted code.

The word also carries an instruction burst-fetch enable and a data snoop enable, which are stored and read back. Two write-only command bits start a cache flush. A flush command raises a one-cycle request strobe to the matching cache and sets a read-only pending flag. The flag clears when that cache pulses its flush-done input. Reads are combinational from the stored state. The caches and the interrupt controller sit outside this block.

Top module: `cache_ctl_reg`

## Requirements
- R1: After the asynchronous active-low reset, the read word is 0, both state outputs are 00 (disabled) and both flush strobes are low.
- R2: A write stores the instruction state in bits [1:0], the data state in bits [3:2], the instruction freeze enable in bit 4, the data freeze enable in bit 5, the burst-fetch enable in bit 16 and the snoop enable in bit 23. From the next cycle these values read back. The state outputs always equal bits [1:0] and [3:2]. The state encodings are 00 disabled, 01 frozen and 11 enabled.
- R3: On an interrupt-acknowledge cycle, if bit 4 is 1 and bits [1:0] hold 11, then bits [1:0] become 01. In every other case, including when no acknowledge and no write occur, the state fields keep their value.
- R4: On an interrupt-acknowledge cycle, if bit 5 is 1 and bits [3:2] hold 11, then bits [3:2] become 01. This happens independently of the instruction-cache rule.
- R5: When a write and an interrupt acknowledge occur in the same cycle, the freeze rule uses the written state and the written freeze-enable values.
- R6: Writing 1 to bit 21 raises the instruction flush strobe, and writing 1 to bit 22 raises the data flush strobe. Each strobe is high for exactly the one cycle after the write. Bits 21 and 22 always read as 0.
- R7: A flush command sets the pending flag of that cache: bit 15 for instruction, bit 14 for data. A pulse on that cache's flush-done input clears the flag. If a command and a done pulse occur in the same cycle, the flag stays set.
- R8: Software writes to bits 14 and 15 have no effect on the pending flags.
- R9: Bits 6-13, 17-20 and 24-31 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Current register value |
| irq_ack_i | input | 1 | Interrupt-acknowledge pulse |
| ic_flush_done_i | input | 1 | Instruction cache flush complete pulse |
| dc_flush_done_i | input | 1 | Data cache flush complete pulse |
| ic_state_o | output | 2 | Instruction cache state |
| dc_state_o | output | 2 | Data cache state |
| ic_flush_req_o | output | 1 | Instruction cache flush request strobe |
| dc_flush_req_o | output | 1 | Data cache flush request strobe |

## Verification
The assertions check on every cycle:
- the freeze transition of each cache after an acknowledge, whether or not a write occurs in the same cycle;
- that the state fields hold their value in quiet cycles;
- that each flush strobe is preceded by a command and is followed by its pending flag;
- that a done pulse clears the flag, and that writes leave the flag alone.

The bench scenarios are the only place where the following are shown:
- the reset value;
- the full readback of the stored fields;
- the cases where the freeze rule must not fire (states 00 and 01, or a disarmed enable);
- the priority of a command over a done pulse in the same cycle;
- that the reserved and command bits read as zero.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
  localparam int unsigned IC_ST_LSB   = 0;
  localparam int unsigned DC_ST_LSB   = 2;
  localparam int unsigned IC_FRZ_BIT  = 4;
  localparam int unsigned DC_FRZ_BIT  = 5;
  localparam int unsigned DC_PEND_BIT = 14;
  localparam int unsigned IC_PEND_BIT = 15;
  localparam int unsigned BURST_BIT   = 16;
  localparam int unsigned IC_FL_BIT   = 21;
  localparam int unsigned DC_FL_BIT   = 22;
  localparam int unsigned SNOOP_BIT   = 23;
  localparam int unsigned NUM_CACHES  = 2;
  localparam int unsigned ST_W        = 2;

  localparam logic [ST_W-1:0] ST_OFF = 2'b00;
  localparam logic [ST_W-1:0] ST_FRZ = 2'b01;
  localparam logic [ST_W-1:0] ST_ON  = 2'b11;

  function automatic logic [ST_W-1:0] freeze_apply(
    input logic [ST_W-1:0] st, input logic arm, input logic ack);
    return (ack && arm && st == ST_ON) ? ST_FRZ : st;
  endfunction
endpackage

// File: rtl/cache_state_slot.sv
module cache_state_slot
  import cache_ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [ST_W-1:0] wr_state_i,
  input  logic            wr_frz_i,
  input  logic            irq_ack_i,
  output logic [ST_W-1:0] state_o,
  output logic            frz_o
);
  logic [ST_W-1:0] state_q, state_w;
  logic            frz_q, frz_w;

  // write value wins, then freeze rule sees it
  always_comb begin
    state_w = wr_en_i ? wr_state_i : state_q;
    frz_w   = wr_en_i ? wr_frz_i   : frz_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      frz_q   <= 1'b0;
    end else begin
      state_q <= freeze_apply(state_w, frz_w, irq_ack_i);
      frz_q   <= frz_w;
    end
  end

  assign state_o = state_q;
  assign frz_o   = frz_q;
endmodule

// File: rtl/cache_flush_slot.sv
module cache_flush_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic done_i,
  output logic req_o,
  output logic pend_o
);
  logic req_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= cmd_i;
      if (cmd_i)       pend_q <= 1'b1;
      else if (done_i) pend_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cache_ctl_reg.sv
module cache_ctl_reg
  import cache_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_ack_i,
  input  logic              ic_flush_done_i,
  input  logic              dc_flush_done_i,
  output logic [ST_W-1:0]   ic_state_o,
  output logic [ST_W-1:0]   dc_state_o,
  output logic              ic_flush_req_o,
  output logic              dc_flush_req_o
);
  localparam int unsigned MIN_W = SNOOP_BIT + 1;

  logic [ST_W-1:0]       st   [NUM_CACHES];
  logic [NUM_CACHES-1:0] frz, req, pend, done;
  logic                  burst_q, snoop_q;

  assign done = {dc_flush_done_i, ic_flush_done_i};

  // index 0: instruction cache, index 1: data cache
  for (genvar g = 0; g < NUM_CACHES; g++) begin : g_cache
    localparam int unsigned SL = (g == 0) ? IC_ST_LSB  : DC_ST_LSB;
    localparam int unsigned FB = (g == 0) ? IC_FRZ_BIT : DC_FRZ_BIT;
    localparam int unsigned CB = (g == 0) ? IC_FL_BIT  : DC_FL_BIT;

    cache_state_slot i_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_state_i (wr_data_i[SL +: ST_W]),
      .wr_frz_i   (wr_data_i[FB]),
      .irq_ack_i  (irq_ack_i),
      .state_o    (st[g]),
      .frz_o      (frz[g])
    );

    cache_flush_slot i_flush (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (wr_en_i & wr_data_i[CB]),
      .done_i (done[g]),
      .req_o  (req[g]),
      .pend_o (pend[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      snoop_q <= 1'b0;
    end else if (wr_en_i) begin
      burst_q <= wr_data_i[BURST_BIT];
      snoop_q <= wr_data_i[SNOOP_BIT];
    end
  end

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[IC_ST_LSB +: ST_W]   = st[0];
    rd_data_o[DC_ST_LSB +: ST_W]   = st[1];
    rd_data_o[IC_FRZ_BIT]          = frz[0];
    rd_data_o[DC_FRZ_BIT]          = frz[1];
    rd_data_o[IC_PEND_BIT]         = pend[0];
    rd_data_o[DC_PEND_BIT]         = pend[1];
    rd_data_o[BURST_BIT]           = burst_q;
    rd_data_o[SNOOP_BIT]           = snoop_q;
  end

  assign ic_state_o     = st[0];
  assign dc_state_o     = st[1];
  assign ic_flush_req_o = req[0];
  assign dc_flush_req_o = req[1];

  logic unused_wr;
  assign unused_wr = ^{wr_data_i[DATA_W-1:SNOOP_BIT+1], wr_data_i[20:17],
                       wr_data_i[15:6]};

  if (DATA_W < MIN_W) begin : g_bad_width
    initial $error("cache_ctl_reg: DATA_W too small");
  end
endmodule

// File: rtl/cache_ctl_checker.sv
module cache_ctl_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_ack_i,
  input logic              ic_flush_done_i,
  input logic              dc_flush_done_i,
  input logic [1:0]        ic_state_o,
  input logic [1:0]        dc_state_o,
  input logic              ic_flush_req_o,
  input logic              dc_flush_req_o
);
  assert_wr_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !irq_ack_i) |=> (rd_data_o[3:0] == $past(wr_data_i[3:0])));

  assert_ic_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !wr_en_i && rd_data_o[4] && ic_state_o == 2'b11)
      |=> (ic_state_o == 2'b01));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_ack_i && !wr_en_i) |=> $stable(rd_data_o[5:0]));

  assert_dc_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !wr_en_i && rd_data_o[5] && dc_state_o == 2'b11)
      |=> (dc_state_o == 2'b01));

  assert_wr_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && wr_en_i && wr_data_i[4] && wr_data_i[1:0] == 2'b11)
      |=> (ic_state_o == 2'b01));

  assert_ic_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[21]) |=> (ic_flush_req_o && rd_data_o[15]));

  assert_dc_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[22]) |=> (dc_flush_req_o && rd_data_o[14]));

  assert_strobe_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ic_flush_req_o |-> $past(wr_en_i && wr_data_i[21]));

  assert_ic_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_flush_done_i && !(wr_en_i && wr_data_i[21])) |=> !rd_data_o[15]);

  assert_dc_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_flush_done_i && !(wr_en_i && wr_data_i[22])) |=> !rd_data_o[14]);

  assert_pend_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[21] && !ic_flush_done_i)
      |=> (rd_data_o[15] == $past(rd_data_o[15])));
endmodule

bind cache_ctl_reg cache_ctl_checker #(.DATA_W(DATA_W)) i_cache_ctl_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .rd_data_o       (rd_data_o),
  .irq_ack_i       (irq_ack_i),
  .ic_flush_done_i (ic_flush_done_i),
  .dc_flush_done_i (dc_flush_done_i),
  .ic_state_o      (ic_state_o),
  .dc_state_o      (dc_state_o),
  .ic_flush_req_o  (ic_flush_req_o),
  .dc_flush_req_o  (dc_flush_req_o)
);

// File: tb/test_cache_ctl_reg.sv
`timescale 1ns/1ps
module test_cache_ctl_reg;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq_ack = 1'b0;
  logic              ic_done = 1'b0;
  logic              dc_done = 1'b0;
  logic [1:0]        ic_state, dc_state;
  logic              ic_req, dc_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cache_ctl_reg #(.DATA_W(DATA_W)) i_cache_ctl_reg (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .wr_en_i         (wr_en),
    .wr_data_i       (wr_data),
    .rd_data_o       (rd_data),
    .irq_ack_i       (irq_ack),
    .ic_flush_done_i (ic_done),
    .dc_flush_done_i (dc_done),
    .ic_state_o      (ic_state),
    .dc_state_o      (dc_state),
    .ic_flush_req_o  (ic_req),
    .dc_flush_req_o  (dc_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one clock with the given inputs; returns at the next falling edge
  task automatic step(input logic w, input logic [31:0] d, input logic irq,
                      input logic icd, input logic dcd);
    @(negedge clk);
    wr_en = w; wr_data = d; irq_ack = irq; ic_done = icd; dc_done = dcd;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; irq_ack = 1'b0; ic_done = 1'b0; dc_done = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic irq();
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 rd", rd_data, 32'h0);
    check("R1 states", {28'h0, dc_state, ic_state}, 32'h0);
    check("R1 strobes", {30'h0, dc_req, ic_req}, 32'h0);
  endtask

  task automatic t_rw();
    wr(32'h0081_003F);
    check("R2 readback all", rd_data, 32'h0081_003F);
    check("R2 state outs", {28'h0, dc_state, ic_state}, 32'hF);
    wr(32'h0000_0007);
    check("R2 readback mixed", rd_data, 32'h0000_0007);
    check("R2 dc out", {30'h0, dc_state}, 32'h1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    check("R3 hold idle", rd_data, 32'h0000_0007);
  endtask

  task automatic t_ic_freeze();
    wr(32'h13);
    irq();
    check("R3 ic freeze", rd_data, 32'h11);
    check("R3 ic out", {30'h0, ic_state}, 32'h1);
    irq();
    check("R3 frozen stays", rd_data, 32'h11);
    wr(32'h03);
    irq();
    check("R3 unarmed", rd_data, 32'h03);
    wr(32'h10);
    irq();
    check("R3 disabled stays", rd_data, 32'h10);
  endtask

  task automatic t_dc_freeze();
    wr(32'h2C);
    irq();
    check("R4 dc freeze", rd_data, 32'h24);
    wr(32'h2F);
    irq();
    check("R4 independent", rd_data, 32'h27);
    wr(32'h3F);
    irq();
    check("R4 both", rd_data, 32'h35);
  endtask

  task automatic t_wr_irq();
    step(1'b1, 32'h3F, 1'b1, 1'b0, 1'b0);
    check("R5 write+irq freeze", rd_data, 32'h35);
    wr(32'h3F);
    step(1'b1, 32'h0F, 1'b1, 1'b0, 1'b0);
    check("R5 written enable clear", rd_data, 32'h0F);
  endtask

  task automatic t_flush();
    wr(32'h0020_0000);
    check("R6 ic strobe", {30'h0, dc_req, ic_req}, 32'h1);
    check("R6 R7 ic readback", rd_data, 32'h0000_8000);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    check("R6 ic strobe one cycle", {30'h0, dc_req, ic_req}, 32'h0);
    check("R7 ic pending held", rd_data, 32'h0000_8000);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R7 ic done clears", rd_data, 32'h0);
    wr(32'h0040_0000);
    check("R6 dc strobe", {30'h0, dc_req, ic_req}, 32'h2);
    check("R7 dc pending", rd_data, 32'h0000_4000);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R7 wrong done ignored", rd_data, 32'h0000_4000);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R7 dc done clears", rd_data, 32'h0);
    wr(32'h0020_0000);
    step(1'b1, 32'h0020_0000, 1'b0, 1'b1, 1'b0);
    check("R7 cmd beats done", rd_data, 32'h0000_8000);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_ro();
    wr(32'h0000_C000);
    check("R8 pending not writable", rd_data, 32'h0);
    check("R8 no strobe", {30'h0, dc_req, ic_req}, 32'h0);
    wr(32'h0040_0000);
    wr(32'h0000_0000);
    check("R8 write 0 keeps pending", rd_data, 32'h0000_4000);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reserved();
    wr(32'hFFFF_FFFF);
    check("R9 R6 all ones", rd_data, 32'h0081_C03F);
    check("R6 both strobes", {30'h0, dc_req, ic_req}, 32'h3);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    wr(32'hFF1E_3FC0);
    check("R9 reserved only", rd_data, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_ic_freeze();
    t_dc_freeze();
    t_wr_irq();
    t_flush();
    t_ro();
    t_reserved();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule